// File: doc/BRIEF.md
# Two-Way Cache Maintenance Engine

This block applies maintenance operations to the state array of a small two-way cache. Each way has 256 sets of 16-byte lines. Each entry holds a valid bit, a modified (dirty) bit and a line tag. A request names an action and a scope. The action is invalidate, push (write back and keep), clear (write back and drop), or a search that changes nothing. The scope is one line picked by physical address, a byte range, the whole cache, or a change of the cache enable. When a dirty entry must be written back, the engine raises a request on a write-back port carrying the line address and the way. It then waits for the acknowledge before it changes that entry.

The state array sits inside the block. The lookup and refill logic that normally owns it reach it through a shared port. That port has a fill write, which is honoured only while the engine is idle, and a combinational peek read. The engine is a four-state machine:

- **IDLE**: waits for a request. It moves to SCAN, or to FINISH for an empty range.
- **SCAN**: handles one entry per cycle. It moves to WBWAIT when the entry needs a write-back. After the last entry it moves to FINISH.
- **WBWAIT**: holds the write-back request. On the acknowledge it updates the entry, then returns to SCAN or goes on to FINISH.
- **FINISH**: pulses done, then returns to IDLE.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy, done, wb_req, cache_en and wbuf_en are low, and every entry reads back invalid and clean.
- R2: Action code 1 (invalidate) clears both valid and modified on each entry it acts on, with no write-back.
- R3: Action code 2 (push) writes back an entry that is valid and modified, then clears only its modified bit. Any other entry is left unchanged.
- R4: Action code 3 (clear) writes back an entry that is valid and modified, then clears valid and modified. Otherwise it clears only the valid bit.
- R5: Action code 0 (search) completes with done but changes no entry and issues no write-back.
- R6: Scope code 0 (line) rounds the address down to 16 bytes. It takes set = addr[11:4] and tag = addr[31:12], and acts only on the ways of that set whose entry is valid with an equal tag.
- R7: Scope code 2 (range) acts, as the line scope does, on every line from the aligned start address through the line holding byte addr+len-1. A length of 0 touches nothing.
- R8: A range request with length at least 4096 bytes (half the cache) is run as a whole-cache sweep, whatever the address.
- R9: Scope code 1 (whole) acts on every entry without a tag compare. It visits sets 0 to 255 in ascending order, way 0 before way 1, so write-backs leave in that order.
- R10: wb_req stays high with wb_addr = {tag, set, 4'b0} and wb_way stable until wb_ack. The sweep stalls meanwhile, and the entry's bits change only after the acknowledge.
- R11: Scope code 3 (enable) runs a full invalidate first. cache_en and wbuf_en take req_enable in the cycle done is high, and not earlier.
- R12: busy is high from the cycle after a request is accepted through the done cycle. done lasts one cycle. A request that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_scope | input | 2 | 0 line, 1 whole, 2 range, 3 enable change |
| req_cmd | input | 2 | 0 search, 1 invalidate, 2 push, 3 clear |
| req_addr | input | 32 | Physical byte address |
| req_len | input | 32 | Range length in bytes |
| req_enable | input | 1 | New enable value for scope 3 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Line address of the write-back |
| wb_way | output | 1 | Way of the write-back |
| wb_ack | input | 1 | Write-back acknowledge |
| cache_en | output | 1 | Cache enable |
| wbuf_en | output | 1 | Write-buffer enable |
| fill_we | input | 1 | Shared-port entry write, ignored while busy |
| fill_set | input | 8 | Set for the fill write |
| fill_way | input | 1 | Way for the fill write |
| fill_valid | input | 1 | Valid bit to write |
| fill_dirty | input | 1 | Modified bit to write |
| fill_tag | input | 20 | Tag to write |
| peek_set | input | 8 | Set for the shared-port read |
| peek_way | input | 1 | Way for the shared-port read |
| peek_valid | output | 1 | Valid bit read |
| peek_dirty | output | 1 | Modified bit read |
| peek_tag | output | 20 | Tag read |

## Verification
The hardest state to reach is a sweep stalled on a write-back while a second request arrives. That request must be dropped, and the entry under write-back must keep its old bits until the acknowledge. The bench withholds wb_ack on the first dirty line of a whole-cache push. While the acknowledge is withheld, it peeks that entry and issues an invalidate aimed at a later dirty line. It then releases the acknowledge and checks that the later line shows push, not invalidate, results. Range requests of 4095 and 4096 bytes at an address that hits nothing separate the line-by-line walk from the promoted sweep.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_INVAL  = 2'd1,
        OP_PUSH   = 2'd2,
        OP_CLEAR  = 2'd3
    } mt_op_e;

    typedef enum logic [1:0] {
        SC_LINE   = 2'd0,
        SC_WHOLE  = 2'd1,
        SC_RANGE  = 2'd2,
        SC_ENABLE = 2'd3
    } mt_scope_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_WBWAIT = 2'd2,
        ST_FINISH = 2'd3
    } mt_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } mt_bits_t;
endpackage

// File: rtl/mt_tag_store.sv
module mt_tag_store
    import mt_pkg::*;
#(
    parameter int ENT_W = 9,
    parameter int TAG_W = 20,
    localparam int ENTS = 1 << ENT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ENT_W-1:0] w_idx,
    input  mt_bits_t         w_bits,
    input  logic [TAG_W-1:0] w_tag,
    input  logic [ENT_W-1:0] r_idx,
    output mt_bits_t         r_bits,
    output logic [TAG_W-1:0] r_tag,
    input  logic [ENT_W-1:0] p_idx,
    output mt_bits_t         p_bits,
    output logic [TAG_W-1:0] p_tag
);
    mt_bits_t         bits_q [ENTS];
    logic [TAG_W-1:0] tag_q  [ENTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTS; i++) begin
                bits_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else if (we) begin
            bits_q[w_idx] <= w_bits;
            tag_q[w_idx]  <= w_tag;
        end
    end

    assign r_bits = bits_q[r_idx];
    assign r_tag  = tag_q[r_idx];
    assign p_bits = bits_q[p_idx];
    assign p_tag  = tag_q[p_idx];
endmodule

// File: rtl/mt_action_eval.sv
module mt_action_eval
    import mt_pkg::*;
(
    input  mt_op_e   op,
    input  logic     hit,
    input  mt_bits_t cur,
    output mt_bits_t nxt,
    output logic     need_wb,
    output logic     upd
);
    logic dirty_line;
    assign dirty_line = cur.valid && cur.dirty;

    always_comb begin
        nxt     = cur;
        need_wb = 1'b0;
        upd     = 1'b0;
        if (hit) begin
            unique case (op)
                OP_SEARCH: upd = 1'b0;
                OP_INVAL: begin
                    nxt = '0;
                    upd = 1'b1;
                end
                OP_PUSH: begin
                    need_wb   = dirty_line;
                    nxt.dirty = dirty_line ? 1'b0 : cur.dirty;
                    upd       = 1'b1;
                end
                OP_CLEAR: begin
                    need_wb   = dirty_line;
                    nxt.valid = 1'b0;
                    nxt.dirty = dirty_line ? 1'b0 : cur.dirty;
                    upd       = 1'b1;
                end
                default: upd = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import mt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WAY_BYTES  = 4096,
    parameter int WAYS       = 2,
    localparam int OFFS_W = $clog2(LINE_BYTES),
    localparam int SETS   = WAY_BYTES / LINE_BYTES,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = ADDR_W - OFFS_W,
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_scope,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    input  logic              req_enable,
    output logic              busy,
    output logic              done,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WAY_W-1:0]  wb_way,
    input  logic              wb_ack,
    output logic              cache_en,
    output logic              wbuf_en,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              fill_valid,
    input  logic              fill_dirty,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [IDX_W-1:0]  peek_set,
    input  logic [WAY_W-1:0]  peek_way,
    output logic              peek_valid,
    output logic              peek_dirty,
    output logic [TAG_W-1:0]  peek_tag
);
    localparam int ENT_W = IDX_W + WAY_W;
    localparam logic [ADDR_W-1:0] HALF_BYTES = ADDR_W'(WAYS * WAY_BYTES / 2);
    localparam logic [WAY_W-1:0]  LAST_WAY   = WAY_W'(WAYS - 1);

    mt_state_e state_q, state_d;
    mt_op_e    op_q, start_op;
    mt_scope_e scope_in;
    logic [LINE_W-1:0] cur_line, last_line, start_line, stop_line;
    logic [WAY_W-1:0]  way_q;
    logic              tagm_q, start_tagm, en_req_q, en_val_q, cache_en_q, wbuf_en_q;
    logic              range_empty, range_big;
    logic [ADDR_W:0]   range_end;

    logic [IDX_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    mt_bits_t          r_bits, p_bits, nxt_bits, w_bits;
    logic [TAG_W-1:0]  r_tag, w_tag;
    logic              hit, need_wb, upd, step, last_ent, st_we;
    logic [ENT_W-1:0]  w_idx;

    assign scope_in    = mt_scope_e'(req_scope);
    assign range_big   = (req_len >= HALF_BYTES);
    assign range_empty = (req_len == '0);
    assign range_end   = {1'b0, req_addr} + {1'b0, req_len} - (ADDR_W+1)'(1);

    // Request decode: cursor limits, tag matching and the effective action
    always_comb begin
        start_op   = mt_op_e'(req_cmd);
        start_line = req_addr[ADDR_W-1:OFFS_W];
        stop_line  = req_addr[ADDR_W-1:OFFS_W];
        start_tagm = 1'b1;
        if (scope_in == SC_WHOLE || scope_in == SC_ENABLE ||
            (scope_in == SC_RANGE && range_big)) begin
            start_line = '0;
            stop_line  = LINE_W'(SETS - 1);
            start_tagm = 1'b0;
        end else if (scope_in == SC_RANGE) begin
            stop_line = range_end[ADDR_W-1:OFFS_W];
        end
        if (scope_in == SC_ENABLE) start_op = OP_INVAL;
    end

    assign cur_set = cur_line[IDX_W-1:0];
    assign cur_tag = cur_line[LINE_W-1:IDX_W];
    assign hit     = tagm_q ? (r_bits.valid && (r_tag == cur_tag)) : 1'b1;

    mt_action_eval eval_i (
        .op(op_q), .hit(hit), .cur(r_bits),
        .nxt(nxt_bits), .need_wb(need_wb), .upd(upd)
    );

    assign step     = (state_q == ST_SCAN && !need_wb) || (state_q == ST_WBWAIT && wb_ack);
    assign last_ent = (way_q == LAST_WAY) && (cur_line == last_line);

    // Shared array write port: engine has priority, fills only when idle
    always_comb begin
        st_we  = 1'b0;
        w_idx  = {cur_set, way_q};
        w_bits = nxt_bits;
        w_tag  = r_tag;
        if (step) begin
            st_we = upd;
        end else if (state_q == ST_IDLE && fill_we) begin
            st_we  = 1'b1;
            w_idx  = {fill_set, fill_way};
            w_bits = '{valid: fill_valid, dirty: fill_dirty};
            w_tag  = fill_tag;
        end
    end

    mt_tag_store #(.ENT_W(ENT_W), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .w_idx(w_idx), .w_bits(w_bits), .w_tag(w_tag),
        .r_idx({cur_set, way_q}), .r_bits(r_bits), .r_tag(r_tag),
        .p_idx({peek_set, peek_way}), .p_bits(p_bits), .p_tag(peek_tag)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)
                state_d = (scope_in == SC_RANGE && range_empty) ? ST_FINISH : ST_SCAN;
            ST_SCAN: begin
                if (need_wb)       state_d = ST_WBWAIT;
                else if (last_ent) state_d = ST_FINISH;
            end
            ST_WBWAIT: if (wb_ack) state_d = last_ent ? ST_FINISH : ST_SCAN;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Cursor and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line   <= '0;
            last_line  <= '0;
            way_q      <= '0;
            op_q       <= OP_SEARCH;
            tagm_q     <= 1'b0;
            en_req_q   <= 1'b0;
            en_val_q   <= 1'b0;
            cache_en_q <= 1'b0;
            wbuf_en_q  <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            cur_line  <= start_line;
            last_line <= stop_line;
            way_q     <= '0;
            op_q      <= start_op;
            tagm_q    <= start_tagm;
            en_req_q  <= (scope_in == SC_ENABLE);
            en_val_q  <= req_enable;
        end else if (step) begin
            if (way_q == LAST_WAY) begin
                way_q <= '0;
                if (cur_line != last_line) cur_line <= cur_line + LINE_W'(1);
            end else begin
                way_q <= way_q + WAY_W'(1);
            end
            if (last_ent && en_req_q) begin
                cache_en_q <= en_val_q;
                wbuf_en_q  <= en_val_q;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        wb_req     = (state_q == ST_WBWAIT);
        wb_addr    = {r_tag, cur_set, {OFFS_W{1'b0}}};
        wb_way     = way_q;
        cache_en   = cache_en_q;
        wbuf_en    = wbuf_en_q;
        peek_valid = p_bits.valid;
        peek_dirty = p_bits.dirty;
    end
endmodule

// File: rtl/mt_maint_checker.sv
module mt_maint_checker #(
    parameter int ADDR_W = 32,
    parameter int WAY_W  = 1,
    parameter int OFFS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [WAY_W-1:0]  wb_way,
    input logic              cache_en,
    input logic              wbuf_en
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_way)));

    // R10
    wb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (busy && (wb_addr[OFFS_W-1:0] == '0)));

    // R11
    en_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cache_en) || !$stable(wbuf_en)) |-> done);
endmodule

bind cache_maint_engine mt_maint_checker #(
    .ADDR_W(ADDR_W), .WAY_W(WAY_W), .OFFS_W(OFFS_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_way(wb_way),
    .cache_en(cache_en), .wbuf_en(wbuf_en)
);

// File: tb/cache_maint_engine_tb_top.sv
module cache_maint_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    typedef struct packed {
        logic [1:0]  scope;
        logic [1:0]  cmd;
        logic [31:0] addr;
        logic [31:0] len;
        logic [7:0]  n_wb;
        logic [31:0] first_wb;
        logic [31:0] last_wb;
        logic [7:0]  bits;   // {a,b,c,d}, each {valid,dirty}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 32'h00012057, 32'd0,    8'd0, 32'h0,        32'h0,        8'b00_10_11_01}, // R2 R6
        '{2'd0, 2'd2, 32'h00012050, 32'd0,    8'd1, 32'h00012050, 32'h00012050, 8'b10_10_11_01}, // R3 R6
        '{2'd0, 2'd3, 32'h00034050, 32'd0,    8'd0, 32'h0,        32'h0,        8'b11_00_11_01}, // R4 R6
        '{2'd0, 2'd2, 32'h00099050, 32'd0,    8'd0, 32'h0,        32'h0,        8'b11_10_11_01}, // R6 miss
        '{2'd2, 2'd2, 32'h0001204C, 32'h18,   8'd2, 32'h00012050, 32'h00012060, 8'b10_10_10_01}, // R7
        '{2'd2, 2'd3, 32'h00012050, 32'h10,   8'd1, 32'h00012050, 32'h00012050, 8'b00_10_11_01}, // R7 R4
        '{2'd1, 2'd2, 32'h0,        32'd0,    8'd2, 32'h00012050, 32'h00012060, 8'b10_10_10_01}, // R9 R3
        '{2'd1, 2'd3, 32'h0,        32'd0,    8'd2, 32'h00012050, 32'h00012060, 8'b00_00_00_01}, // R9 R4
        '{2'd1, 2'd1, 32'h0,        32'd0,    8'd0, 32'h0,        32'h0,        8'b00_00_00_00}, // R9 R2
        '{2'd2, 2'd1, 32'h00099000, 32'd4096, 8'd0, 32'h0,        32'h0,        8'b00_00_00_00}, // R8
        '{2'd2, 2'd1, 32'h00099000, 32'd4095, 8'd0, 32'h0,        32'h0,        8'b11_10_11_01}, // R8 below
        '{2'd1, 2'd0, 32'h0,        32'd0,    8'd0, 32'h0,        32'h0,        8'b11_10_11_01}, // R5
        '{2'd2, 2'd2, 32'h00012050, 32'd0,    8'd0, 32'h0,        32'h0,        8'b11_10_11_01}  // R7 empty
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_scope = '0;
    logic [1:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        req_enable = 1'b0;
    logic        busy, done, wb_req, cache_en, wbuf_en;
    logic [31:0] wb_addr;
    logic        wb_way;
    logic        wb_ack = 1'b0;
    logic        fill_we = 1'b0;
    logic [7:0]  fill_set = '0;
    logic        fill_way = 1'b0;
    logic        fill_valid = 1'b0;
    logic        fill_dirty = 1'b0;
    logic [19:0] fill_tag = '0;
    logic [7:0]  peek_set = '0;
    logic        peek_way = 1'b0;
    logic        peek_valid, peek_dirty;
    logic [19:0] peek_tag;

    int errors = 0;
    int total = 0;
    int n_wb;
    logic [31:0] first_wb, last_wb;
    logic en_early;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_maint_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_scope(req_scope),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_enable(req_enable), .busy(busy), .done(done), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_way(wb_way), .wb_ack(wb_ack),
        .cache_en(cache_en), .wbuf_en(wbuf_en), .fill_we(fill_we),
        .fill_set(fill_set), .fill_way(fill_way), .fill_valid(fill_valid),
        .fill_dirty(fill_dirty), .fill_tag(fill_tag), .peek_set(peek_set),
        .peek_way(peek_way), .peek_valid(peek_valid), .peek_dirty(peek_dirty),
        .peek_tag(peek_tag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] s, input logic w, input logic v, input logic d, input logic [19:0] t);
        @(negedge clk);
        fill_we = 1'b1; fill_set = s; fill_way = w;
        fill_valid = v; fill_dirty = d; fill_tag = t;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic load_pattern();
        fill(8'd5,   1'b0, 1'b1, 1'b1, 20'h00012);
        fill(8'd5,   1'b1, 1'b1, 1'b0, 20'h00034);
        fill(8'd6,   1'b1, 1'b1, 1'b1, 20'h00012);
        fill(8'd200, 1'b0, 1'b0, 1'b1, 20'h00777);
    endtask

    task automatic peek(input logic [7:0] s, input logic w, output logic [1:0] vd);
        peek_set = s; peek_way = w;
        #1;
        vd = {peek_valid, peek_dirty};
    endtask

    task automatic peek_all(output logic [7:0] bits);
        logic [1:0] a, b, c, d;
        peek(8'd5, 1'b0, a);
        peek(8'd5, 1'b1, b);
        peek(8'd6, 1'b1, c);
        peek(8'd200, 1'b0, d);
        bits = {a, b, c, d};
    endtask

    // Issues one request, acknowledges write-backs at once, waits for done
    task automatic run_op(input logic [1:0] sc, input logic [1:0] cmd,
                          input logic [31:0] ad, input logic [31:0] ln, input logic en);
        int guard;
        logic en_start;
        @(negedge clk);
        req_scope = sc; req_cmd = cmd; req_addr = ad; req_len = ln;
        req_enable = en; req_valid = 1'b1;
        en_start = cache_en;
        @(negedge clk);
        req_valid = 1'b0;
        n_wb = 0; first_wb = '0; last_wb = '0; en_early = 1'b0;
        check(busy == 1'b1, "R12 busy after accept", {31'b0, busy}, 32'd1);
        guard = 0;
        while (!done && guard < 5000) begin
            if (cache_en != en_start) en_early = 1'b1;
            if (wb_req && !wb_ack) begin
                n_wb++;
                if (n_wb == 1) first_wb = wb_addr;
                last_wb = wb_addr;
                wb_ack = 1'b1;
            end else begin
                wb_ack = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        wb_ack = 1'b0;
        check(done == 1'b1, "R12 done reached", {31'b0, done}, 32'd1);
        @(negedge clk);
        check(done == 1'b0, "R12 done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        errors++;
        total++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        logic [7:0] bits;
        logic [1:0] vd;
        int hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'd0);
        check(done == 1'b0, "R1 done", {31'b0, done}, 32'd0);
        check(wb_req == 1'b0, "R1 wb_req", {31'b0, wb_req}, 32'd0);
        check({cache_en, wbuf_en} == 2'b00, "R1 enables", {30'b0, cache_en, wbuf_en}, 32'd0);
        peek_all(bits);
        check(bits == 8'h00, "R1 entries clear", {24'b0, bits}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            load_pattern();
            run_op(VECS[i].scope, VECS[i].cmd, VECS[i].addr, VECS[i].len, 1'b0);
            peek_all(bits);
            check(bits == VECS[i].bits, $sformatf("R2-7 vec%0d entry bits", i),
                  {24'b0, bits}, {24'b0, VECS[i].bits});
            check(n_wb == int'(VECS[i].n_wb), $sformatf("R3 R4 vec%0d wb count", i),
                  32'(n_wb), {24'b0, VECS[i].n_wb});
            if (VECS[i].n_wb != 0) begin
                check(first_wb == VECS[i].first_wb, $sformatf("R9 vec%0d first wb", i),
                      first_wb, VECS[i].first_wb);
                check(last_wb == VECS[i].last_wb, $sformatf("R9 vec%0d last wb", i),
                      last_wb, VECS[i].last_wb);
            end
        end

        // R10 and R12: stalled write-back, request while busy ignored
        load_pattern();
        @(negedge clk);
        req_scope = 2'd1; req_cmd = 2'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        hold = 0;
        while (!wb_req && hold < 1000) begin
            @(negedge clk);
            hold++;
        end
        check(wb_addr == 32'h00012050, "R10 stalled wb addr", wb_addr, 32'h00012050);
        check(wb_way == 1'b0, "R10 stalled wb way", {31'b0, wb_way}, 32'd0);
        req_scope = 2'd0; req_cmd = 2'd1; req_addr = 32'h00012060; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (9) @(negedge clk);
        check(wb_req == 1'b1, "R10 wb_req held", {31'b0, wb_req}, 32'd1);
        check(wb_addr == 32'h00012050, "R10 wb addr stable", wb_addr, 32'h00012050);
        peek(8'd5, 1'b0, vd);
        check(vd == 2'b11, "R10 bits unchanged before ack", {30'b0, vd}, 32'd3);
        hold = 0;
        while (!done && hold < 2000) begin
            wb_ack = wb_req && !wb_ack;
            @(negedge clk);
            hold++;
        end
        wb_ack = 1'b0;
        @(negedge clk);
        peek_all(bits);
        check(bits == 8'b10_10_10_01, "R12 busy request ignored", {24'b0, bits}, 32'b10_10_10_01);

        // R11 enable change after invalidate
        load_pattern();
        run_op(2'd3, 2'd0, 32'h0, 32'd0, 1'b1);
        check(en_early == 1'b0, "R11 enable not early", {31'b0, en_early}, 32'd0);
        check({cache_en, wbuf_en} == 2'b11, "R11 enables set", {30'b0, cache_en, wbuf_en}, 32'd3);
        peek_all(bits);
        check(bits == 8'h00, "R11 invalidated first", {24'b0, bits}, 32'd0);
        check(n_wb == 0, "R11 no write-back", 32'(n_wb), 32'd0);
        run_op(2'd3, 2'd0, 32'h0, 32'd0, 1'b0);
        check({cache_en, wbuf_en} == 2'b00, "R11 enables cleared", {30'b0, cache_en, wbuf_en}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule